// File: doc/BRIEF.md
# Receiver Detect and Termination Controller

This block sits in each lane group of a multi-lane serial redriver and decides how the analog termination of every lane is set. After the functional detect reset is released, each lane runs a timed far-end load probe. The output pin is held in weak pull-up while a timer runs. When the timer expires, the level of a load-sense comparator is captured once and kept as the lane's "receiver present" flag.

The termination selects are decoded without a register stage from the global power-down, the global detect reset, the per-lane detect enable, the per-lane signal-present flag and the captured detect flag. When detection is bypassed (detect enable low), a lane terminates its input and drives its output whenever a signal is present, whatever the probe found. When detection is enabled, a lane terminates its input only once a receiver has been found. In that case it still drives only while a signal is present.

The analog parts (termination resistors, comparator, equaliser) lie outside this block. They are seen here only as digital levels. The comparator level passes through a two-flop synchroniser before it is captured.

Top module: `rxdet_term_ctrl`

## Requirements
- R1: While `sys_rst_n` is low at a clock edge, every `detected` bit is cleared and every probe returns to idle.
- R2: While `pwr_dn_n` is low, each lane selects input high-impedance (`in_term` bit 2i) and output high-impedance (`out_term` bit 3i), whatever the other inputs are.
- R3: With power up and `det_rst_n` low, each lane selects input high-impedance and output weak pull-up (`out_term` bit 3i+1). A clock edge that samples `det_rst_n` low clears `detected`.
- R4: With power up, `det_rst_n` high and `det_en[i]` low, lane i selects 50-ohm input pull-down (`in_term` bit 2i+1). Its output is 50-ohm drive (`out_term` bit 3i+2) when `sig_det[i]` is high and weak pull-up otherwise. `detected[i]` has no effect on this.
- R5: With power up, `det_rst_n` high, `det_en[i]` high and `detected[i]` low, lane i selects input high-impedance and output weak pull-up, even when `sig_det[i]` is high.
- R6: With power up, `det_rst_n` high, `det_en[i]` high and `detected[i]` high, lane i selects 50-ohm input pull-down. Its output drives only while `sig_det[i]` is high and is weak pull-up otherwise.
- R7: A probe starts at the first clock edge that samples `det_rst_n` high after it sampled it low (or after `sys_rst_n` released), with power up. `detected[i]` takes its value TIMEOUT edges later. That value is the level `cmp_lvl[i]` had two edges before the capture edge.
- R8: Once captured, `detected[i]` does not follow later changes of `cmp_lvl[i]` while power and `det_rst_n` stay high.
- R9: A clock edge that samples `pwr_dn_n` low aborts any probe in progress and clears `detected`. No new probe starts until `det_rst_n` goes low and rises again.
- R10: For every lane, exactly one bit of its 2-bit input select and exactly one bit of its 3-bit output select is high.
- R11: Lanes capture their own comparator levels independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Synchronous active-low reset of the control logic |
| pwr_dn_n | input | 1 | Active-low power-down of all lanes |
| det_rst_n | input | 1 | Active-low detect reset; its rising edge starts a probe |
| det_en | input | LANES | Per-lane detect enable (low = detection bypassed) |
| sig_det | input | LANES | Per-lane input signal present |
| cmp_lvl | input | LANES | Per-lane load-sense comparator level (asynchronous) |
| detected | output | LANES | Per-lane captured receiver-present flag |
| in_term | output | 2*LANES | Per-lane one-hot input termination: bit 2i high-Z, bit 2i+1 50-ohm pull-down |
| out_term | output | 3*LANES | Per-lane one-hot output mode: bit 3i high-Z, 3i+1 weak pull-up, 3i+2 50-ohm drive |

## Verification
The hardest case to reach is a power-down pulse that lands in the middle of a probe while `det_rst_n` stays high. The probe must be abandoned and must not restart on its own. The bench reaches this case with a directed sequence: it starts a probe, pulses power-down a few cycles later, waits past the timeout to confirm the flag stays clear, and then toggles the detect reset to show that a fresh probe completes. A long random phase then mixes rare power-down and detect-reset pulses with changing enables, signal flags and comparator levels, so that probes are cut short at many different counter values.

// File: rtl/rxdet_pkg.sv
// Package: shared types for the receiver detect termination controller.
// Assumes: one-hot selects are consumed bit-for-bit by the analog front end.
package rxdet_pkg;

    // Probe sequencer states.
    typedef enum logic [1:0] {
        PRB_IDLE = 2'd0,
        PRB_WAIT = 2'd1,
        PRB_HELD = 2'd2
    } prb_state_e;

    // Input termination select: bit0 high-Z, bit1 50-ohm pull-down.
    typedef struct packed {
        logic pd50;
        logic hiz;
    } in_sel_t;

    // Output mode select: bit0 high-Z, bit1 weak pull-up, bit2 50-ohm drive.
    typedef struct packed {
        logic drv50;
        logic pu_weak;
        logic hiz;
    } out_sel_t;

    localparam int IN_SEL_W  = $bits(in_sel_t);
    localparam int OUT_SEL_W = $bits(out_sel_t);

endpackage

// File: rtl/rxdet_sync.sv
// Module: multi-flop level synchroniser for one asynchronous bit.
// Assumes: input is a slowly changing level; STAGES >= 2.
module rxdet_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rxdet_probe.sv
// Module: per-lane timed load probe. Starts on a rising detect reset,
//         waits TIMEOUT cycles, then captures the synchronised comparator once.
// Assumes: cmp_sync is already synchronous to clk; all controls are synchronous.
module rxdet_probe
    import rxdet_pkg::*;
#(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn_n,
    input  logic det_rst_n,
    input  logic cmp_sync,
    output logic found
);

    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    prb_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             rst_seen_hi;
    logic             start;

    assign start = det_rst_n && !rst_seen_hi;

    // Track detect reset, run the timeout counter and capture the comparator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= PRB_IDLE;
            cnt         <= '0;
            found       <= 1'b0;
            rst_seen_hi <= 1'b0;
        end else begin
            rst_seen_hi <= det_rst_n;
            if (!pwr_dn_n || !det_rst_n) begin
                state <= PRB_IDLE;
                cnt   <= '0;
                found <= 1'b0;
            end else begin
                case (state)
                    PRB_IDLE: begin
                        if (start) begin
                            state <= PRB_WAIT;
                            cnt   <= '0;
                        end
                    end
                    PRB_WAIT: begin
                        if (cnt == CNT_LAST) begin
                            found <= cmp_sync;
                            state <= PRB_HELD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= PRB_HELD;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxdet_term_decode.sv
// Module: combinational decode of termination selects for one lane.
// Assumes: power-down dominates, then detect reset, then detect enable.
module rxdet_term_decode
    import rxdet_pkg::*;
(
    input  logic     pwr_dn_n,
    input  logic     det_rst_n,
    input  logic     det_en,
    input  logic     sig_det,
    input  logic     found,
    output in_sel_t  in_sel,
    output out_sel_t out_sel
);

    logic link_up;

    // Lane may terminate when bypassing detection or when a load was found.
    assign link_up = !det_en || found;

    // Priority decode of the input and output termination modes.
    always_comb begin
        in_sel  = '{pd50: 1'b0, hiz: 1'b1};
        out_sel = '{drv50: 1'b0, pu_weak: 1'b1, hiz: 1'b0};
        if (!pwr_dn_n) begin
            out_sel = '{drv50: 1'b0, pu_weak: 1'b0, hiz: 1'b1};
        end else if (det_rst_n && link_up) begin
            in_sel = '{pd50: 1'b1, hiz: 1'b0};
            if (sig_det) begin
                out_sel = '{drv50: 1'b1, pu_weak: 1'b0, hiz: 1'b0};
            end
        end
    end

endmodule

// File: rtl/rxdet_term_ctrl.sv
// Module: top of the receiver detect termination controller, LANES lanes.
// Assumes: pwr_dn_n, det_rst_n, det_en and sig_det are synchronous to clk;
//          cmp_lvl is asynchronous and synchronised here.
module rxdet_term_ctrl
    import rxdet_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int TIMEOUT     = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       sys_rst_n,
    input  logic                       pwr_dn_n,
    input  logic                       det_rst_n,
    input  logic [LANES-1:0]           det_en,
    input  logic [LANES-1:0]           sig_det,
    input  logic [LANES-1:0]           cmp_lvl,
    output logic [LANES-1:0]           detected,
    output logic [IN_SEL_W*LANES-1:0]  in_term,
    output logic [OUT_SEL_W*LANES-1:0] out_term
);

    // One synchroniser, probe and decoder per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic     cmp_sync;
        in_sel_t  in_sel;
        out_sel_t out_sel;

        rxdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (sys_rst_n),
            .d     (cmp_lvl[g]),
            .q     (cmp_sync)
        );

        rxdet_probe #(.TIMEOUT(TIMEOUT)) u_probe (
            .clk       (clk),
            .rst_n     (sys_rst_n),
            .pwr_dn_n  (pwr_dn_n),
            .det_rst_n (det_rst_n),
            .cmp_sync  (cmp_sync),
            .found     (detected[g])
        );

        rxdet_term_decode u_dec (
            .pwr_dn_n  (pwr_dn_n),
            .det_rst_n (det_rst_n),
            .det_en    (det_en[g]),
            .sig_det   (sig_det[g]),
            .found     (detected[g]),
            .in_sel    (in_sel),
            .out_sel   (out_sel)
        );

        assign in_term[IN_SEL_W*g +: IN_SEL_W]    = in_sel;
        assign out_term[OUT_SEL_W*g +: OUT_SEL_W] = out_sel;
    end

endmodule

// File: rtl/rxdet_term_ctrl_chk.sv
// Module: property checker bound to rxdet_term_ctrl.
// Assumes: observes top-level ports only.
module rxdet_term_ctrl_chk #(
    parameter int LANES = 4
) (
    input logic                 clk,
    input logic                 sys_rst_n,
    input logic                 pwr_dn_n,
    input logic                 det_rst_n,
    input logic [LANES-1:0]     det_en,
    input logic [LANES-1:0]     sig_det,
    input logic [LANES-1:0]     detected,
    input logic [2*LANES-1:0]   in_term,
    input logic [3*LANES-1:0]   out_term
);

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_IN_ONEHOT: assert property (@(posedge clk) disable iff (!sys_rst_n)
            $countones(in_term[2*g +: 2]) == 1); // R10
        AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!sys_rst_n)
            $countones(out_term[3*g +: 3]) == 1); // R10
        AST_PD_HIZ: assert property (@(posedge clk) disable iff (!sys_rst_n)
            !pwr_dn_n |-> (in_term[2*g] && out_term[3*g])); // R2
        AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!sys_rst_n)
            !det_rst_n |=> !detected[g]); // R3
        AST_BYPASS_TERM: assert property (@(posedge clk) disable iff (!sys_rst_n)
            (pwr_dn_n && det_rst_n && !det_en[g]) |-> in_term[2*g+1]); // R4
        AST_NO_LOAD_HIZ: assert property (@(posedge clk) disable iff (!sys_rst_n)
            (pwr_dn_n && det_rst_n && det_en[g] && !detected[g]) |-> in_term[2*g]); // R5
        AST_DRIVE_NEEDS_SIG: assert property (@(posedge clk) disable iff (!sys_rst_n)
            out_term[3*g+2] |-> sig_det[g]); // R6
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!sys_rst_n)
            (pwr_dn_n && det_rst_n && $past(pwr_dn_n && det_rst_n) && $past(detected[g]))
            |-> detected[g]); // R8
        AST_PD_ABORT: assert property (@(posedge clk) disable iff (!sys_rst_n)
            !pwr_dn_n |=> !detected[g]); // R9
    end

endmodule

bind rxdet_term_ctrl rxdet_term_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .pwr_dn_n  (pwr_dn_n),
    .det_rst_n (det_rst_n),
    .det_en    (det_en),
    .sig_det   (sig_det),
    .detected  (detected),
    .in_term   (in_term),
    .out_term  (out_term)
);

// File: tb/sim_rxdet_term_ctrl.sv
`timescale 1ns/1ps
module sim_rxdet_term_ctrl;

    localparam int LANES   = 4;
    localparam int TIMEOUT = 24;

    logic             clk = 1'b0;
    logic             sys_rst_n = 1'b0;
    logic             pwr_dn_n = 1'b1;
    logic             det_rst_n = 1'b0;
    logic [LANES-1:0] det_en = '0;
    logic [LANES-1:0] sig_det = '0;
    logic [LANES-1:0] cmp_lvl = '0;
    logic [LANES-1:0] detected;
    logic [2*LANES-1:0] in_term;
    logic [3*LANES-1:0] out_term;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rxdet_term_ctrl #(.LANES(LANES), .TIMEOUT(TIMEOUT)) u0 (
        .clk(clk), .sys_rst_n(sys_rst_n), .pwr_dn_n(pwr_dn_n), .det_rst_n(det_rst_n),
        .det_en(det_en), .sig_det(sig_det), .cmp_lvl(cmp_lvl),
        .detected(detected), .in_term(in_term), .out_term(out_term)
    );

    // Bench model of the captured flag, built from R1, R3, R7 and R9.
    int               m_state = 0;
    int               m_cnt = 0;
    logic             m_prev = 1'b0;
    logic [LANES-1:0] m_flag = '0, m_s1 = '0, m_s2 = '0;

    always @(posedge clk) begin
        if (!sys_rst_n) begin
            m_state <= 0; m_cnt <= 0; m_prev <= 1'b0;
            m_flag <= '0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            m_s1 <= cmp_lvl; m_s2 <= m_s1; m_prev <= det_rst_n;
            if (!pwr_dn_n || !det_rst_n) begin
                m_state <= 0; m_cnt <= 0; m_flag <= '0;
            end else if (m_state == 0) begin
                if (!m_prev) begin m_state <= 1; m_cnt <= 0; end
            end else if (m_state == 1) begin
                if (m_cnt == TIMEOUT - 1) begin m_flag <= m_s2; m_state <= 2; end
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    // Expected {out[2:0], in[1:0]} for one lane from R2..R6.
    function automatic logic [4:0] exp_term(logic pd_n, logic rs_n, logic en,
                                            logic sig, logic flg);
        if (!pd_n)            return {3'b001, 2'b01};
        if (!rs_n)            return {3'b010, 2'b01};
        if (!en || flg)       return {(sig ? 3'b100 : 3'b010), 2'b10};
        return {3'b010, 2'b01};
    endfunction

    function automatic string req_of(logic pd_n, logic rs_n, logic en, logic flg);
        if (!pd_n) return "R2";
        if (!rs_n) return "R3";
        if (!en)   return "R4";
        if (!flg)  return "R5";
        return "R6";
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare every lane against the bench model (R10 one-hot included).
    task automatic check_all();
        for (int l = 0; l < LANES; l++) begin
            logic [4:0] e;
            e = exp_term(pwr_dn_n, det_rst_n, det_en[l], sig_det[l], m_flag[l]);
            chk("R7", 8'(detected[l]), 8'(m_flag[l]));
            chk(req_of(pwr_dn_n, det_rst_n, det_en[l], m_flag[l]),
                8'({out_term[3*l +: 3], in_term[2*l +: 2]}), 8'(e));
            chk("R10", 8'($countones(in_term[2*l +: 2]) + $countones(out_term[3*l +: 3])), 8'd2);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        cmp_lvl = 4'b1111;
        @(negedge clk);
        tick(3);
        chk("R1", 8'(detected), 8'h00);            // R1 reset state
        sys_rst_n = 1'b1;
        tick(2);
        chk("R3", 8'({out_term[2:0], in_term[1:0]}), 8'b01001); // R3 det_rst low
        check_all();

        // R7 / R11: probe timing with distinct lane levels.
        det_en = 4'b1111; cmp_lvl = 4'b1010;
        tick(4);
        det_rst_n = 1'b1;
        tick(TIMEOUT);
        chk("R7", 8'(detected), 8'h00);             // one edge before capture
        tick(1);
        chk("R11", 8'(detected), 8'h0A);            // lanes captured independently
        cmp_lvl = 4'b0101;
        tick(10);
        chk("R8", 8'(detected), 8'h0A);             // no tracking after capture
        sig_det = 4'b1111;
        @(posedge clk); @(negedge clk);
        chk("R6", 8'(out_term), 8'(12'b100_010_100_010)); // lanes 1,3 drive
        chk("R5", 8'(in_term),  8'b10_01_10_01);
        check_all();

        // R4: bypass ignores the flag.
        det_en = 4'b0000; sig_det = 4'b0011;
        tick(1);
        chk("R4", 8'(in_term), 8'b10_10_10_10);
        check_all();

        // R9: power-down pulse mid-probe, no self restart.
        det_en = 4'b1111; cmp_lvl = 4'b1111;
        det_rst_n = 1'b0; tick(2);
        det_rst_n = 1'b1; tick(5);
        pwr_dn_n = 1'b0; tick(1);
        chk("R2", 8'(out_term[2:0]), 8'b001);
        pwr_dn_n = 1'b1;
        tick(TIMEOUT + 5);
        chk("R9", 8'(detected), 8'h00);
        det_rst_n = 1'b0; tick(1);
        det_rst_n = 1'b1; tick(TIMEOUT + 2);
        chk("R9", 8'(detected), 8'h0F);             // fresh probe completes
        check_all();

        // Random phase.
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(15) == 0) pwr_dn_n = ~pwr_dn_n;
            else if (!pwr_dn_n && $urandom_range(3) == 0) pwr_dn_n = 1'b1;
            if ($urandom_range(47) == 0) det_rst_n = ~det_rst_n;
            else if (!det_rst_n && $urandom_range(3) == 0) det_rst_n = 1'b1;
            if ($urandom_range(7) == 0) det_en = 4'($urandom);
            sig_det = 4'($urandom);
            if ($urandom_range(5) == 0) cmp_lvl = 4'($urandom);
            tick(1);
            check_all();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule